// File: doc/BRIEF.md
# Station Address ROM Loader

This block runs once after power-up, or whenever it is asked to. It fetches a 48-bit station hardware address from a byte-wide read-only memory and checks it before the rest of the network interface may use it. A one-cycle start request begins a load. The block then issues eight single-byte reads, one at a time, spaced a fixed number of memory locations apart. Each returned byte is stored in the memory with its bit order mirrored, so the block flips it back first. The first six bytes are assembled into the address. All eight are folded together with exclusive-or into a check value.

When the eighth byte has arrived, the block compares the check value with the all-ones pattern. It then emits a one-cycle completion pulse together with either a valid flag or a failure flag. The memory answers each read after a parameterised number of cycles, and the block never has more than one read in flight. The address output changes only when a load succeeds, so a corrupt memory never disturbs an address that was accepted earlier.

Top module: `hwaddr_rom_loader`

## Requirements
- R1: While reset is applied, `done_o`, `valid_o`, `fail_o` and `rom_rd_o` are low and `station_addr_o` is zero.
- R2: Each accepted start produces exactly eight reads. The locations read are 16×j for j = 0..7 (0x00, 0x10, … 0x70), in increasing order.
- R3: Each byte returned by the memory is bit-mirrored before use: memory bit i becomes bit 7−i.
- R4: The mirrored byte from location 0x00 occupies `station_addr_o[47:40]`. Each following location fills the next lower byte, and the byte from location 0x50 occupies `station_addr_o[7:0]`.
- R5: If the exclusive-or of all eight mirrored bytes equals 0xFF, the load ends with `valid_o` high and `fail_o` low, and the new address appears on `station_addr_o`.
- R6: If that exclusive-or differs from 0xFF, the load ends with `fail_o` high and `valid_o` low, and `station_addr_o` keeps its previous value.
- R7: The bytes at locations 0x60 and 0x70 take part only in the check and never change `station_addr_o`.
- R8: `done_o` is high for exactly one cycle per load. In that same cycle `valid_o` and `fail_o` first show the result, and they are never high together.
- R9: A start request that arrives while a load is in progress is ignored: no extra reads are made and only one completion pulse follows.
- R10: In the cycle after a start is accepted, `valid_o` and `fail_o` are both low, and they stay low until the completion pulse.
- R11: Read data is taken `RD_LAT` cycles after the cycle in which `rom_rd_o` is high, and no new read is issued while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin a load |
| rom_rd_o | output | 1 | Read strobe to the memory |
| rom_addr_o | output | ADDR_W | Memory location being read |
| rom_data_i | input | 8 | Memory data, valid RD_LAT cycles after the strobe |
| station_addr_o | output | 48 | Last accepted station address |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | The last load passed its check |
| fail_o | output | 1 | The last load failed its check |

## Verification
Some properties are checked by assertions on every cycle: the completion pulse lasts one cycle, the two result flags are never both high, both flags clear right after an accepted start, the address holds through a failed completion, every read location is a multiple of the stride, and reads never overlap a pending return. The bench scenarios are the only way to show the values themselves. They cover the bit mirroring and byte ordering of the assembled address, and the pass or fail decision for chosen check bytes. They also show that the trailing bytes leave the address untouched, and that a second start in mid-load costs no extra reads. The bench sweeps a single set bit across all 48 address positions with a memory latency of two cycles.

// File: rtl/hwaddr_ld_pkg.sv
package hwaddr_ld_pkg;

  typedef enum logic [1:0] {
    LD_IDLE   = 2'd0,
    LD_ISSUE  = 2'd1,
    LD_WAIT   = 2'd2,
    LD_FINISH = 2'd3
  } ld_state_e;

  function automatic logic [7:0] mirror8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/hwaddr_rst_sync.sv
module hwaddr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hwaddr_rd_track.sv
module hwaddr_rd_track #(
  parameter int RD_LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  output logic ret_o
);
  logic [RD_LAT-1:0] pipe_q;
  logic [RD_LAT-1:0] pipe_d;

  generate
    if (RD_LAT == 1) begin : g_single
      always_comb pipe_d = rd_i;
    end else begin : g_chain
      always_comb pipe_d = {pipe_q[RD_LAT-2:0], rd_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign ret_o = pipe_q[RD_LAT-1];

  // R11: a read is never issued while an earlier one is still returning
  assert_one_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> (pipe_q == '0));
endmodule

// File: rtl/hwaddr_seq.sv
module hwaddr_seq
  import hwaddr_ld_pkg::*;
#(
  parameter int BYTE_CNT = 8,
  parameter int STRIDE   = 16,
  parameter int ADDR_W   = 8,
  localparam int IDX_W   = $clog2(BYTE_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ret_i,
  output logic             rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             finish_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_CNT - 1);

  ld_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    rd_o     = 1'b0;
    accept_o = 1'b0;
    finish_o = 1'b0;
    case (state_q)
      LD_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          idx_d    = '0;
          state_d  = LD_ISSUE;
        end
      end
      LD_ISSUE: begin
        rd_o    = 1'b1;
        state_d = LD_WAIT;
      end
      LD_WAIT: begin
        if (ret_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = LD_FINISH;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = LD_ISSUE;
          end
        end
      end
      default: begin
        finish_o = 1'b1;
        state_d  = LD_IDLE;
      end
    endcase
  end

  assign idx_en = (idx_d != idx_q);
  assign idx_o  = idx_q;
  assign addr_o = ADDR_W'(idx_q) * ADDR_W'(STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // R11: returned data only ever arrives while a read is awaited
  assert_ret_while_waiting_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> (state_q == LD_WAIT));
endmodule

// File: rtl/hwaddr_accum.sv
module hwaddr_accum
  import hwaddr_ld_pkg::*;
#(
  parameter int         BYTE_CNT   = 8,
  parameter int         ADDR_BYTES = 6,
  parameter logic [7:0] CHECK_VAL  = 8'hFF,
  localparam int        IDX_W      = $clog2(BYTE_CNT),
  localparam int        SA_W       = ADDR_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic             finish_i,
  output logic [SA_W-1:0]  station_addr_o,
  output logic             done_o,
  output logic             valid_o,
  output logic             fail_o
);
  logic [SA_W-1:0] shadow_q, shadow_d, addr_d;
  logic [7:0]      chk_q, chk_d, flipped;
  logic            valid_d, fail_d, ok;
  logic            work_en, addr_en;

  assign flipped = mirror8(data_i);
  assign ok      = (chk_q == CHECK_VAL);

  always_comb begin
    shadow_d = shadow_q;
    chk_d    = chk_q;
    valid_d  = valid_o;
    fail_d   = fail_o;
    addr_d   = station_addr_o;
    if (clear_i) begin
      chk_d   = '0;
      valid_d = 1'b0;
      fail_d  = 1'b0;
    end
    if (take_i) begin
      chk_d = chk_q ^ flipped;
      for (int k = 0; k < ADDR_BYTES; k++) begin
        if (idx_i == IDX_W'(k)) shadow_d[(ADDR_BYTES-1-k)*8 +: 8] = flipped;
      end
    end
    if (finish_i) begin
      valid_d = ok;
      fail_d  = !ok;
      if (ok) addr_d = shadow_q;
    end
  end

  assign work_en = clear_i | take_i | finish_i;
  assign addr_en = finish_i & ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      chk_q    <= '0;
      valid_o  <= 1'b0;
      fail_o   <= 1'b0;
    end else if (work_en) begin
      shadow_q <= shadow_d;
      chk_q    <= chk_d;
      valid_o  <= valid_d;
      fail_o   <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       station_addr_o <= '0;
    else if (addr_en) station_addr_o <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= finish_i;
  end

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5: the valid flag only comes up together with completion
  assert_valid_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> done_o);
  // R6: the failure flag only comes up together with completion
  assert_fail_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> done_o);
endmodule

// File: rtl/hwaddr_rom_loader.sv
module hwaddr_rom_loader #(
  parameter int         BYTE_CNT   = 8,
  parameter int         ADDR_BYTES = 6,
  parameter int         STRIDE     = 16,
  parameter int         ADDR_W     = 8,
  parameter int         RD_LAT     = 1,
  parameter logic [7:0] CHECK_VAL  = 8'hFF,
  localparam int        IDX_W      = $clog2(BYTE_CNT),
  localparam int        SA_W       = ADDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rom_rd_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic [SA_W-1:0]   station_addr_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              fail_o
);
  logic             rst_sync_n;
  logic             ret;
  logic             accept;
  logic             finish;
  logic [IDX_W-1:0] idx;

  hwaddr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hwaddr_seq #(
    .BYTE_CNT (BYTE_CNT),
    .STRIDE   (STRIDE),
    .ADDR_W   (ADDR_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .ret_i    (ret),
    .rd_o     (rom_rd_o),
    .addr_o   (rom_addr_o),
    .idx_o    (idx),
    .accept_o (accept),
    .finish_o (finish)
  );

  hwaddr_rd_track #(
    .RD_LAT (RD_LAT)
  ) u_track (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd_i  (rom_rd_o),
    .ret_o (ret)
  );

  hwaddr_accum #(
    .BYTE_CNT   (BYTE_CNT),
    .ADDR_BYTES (ADDR_BYTES),
    .CHECK_VAL  (CHECK_VAL)
  ) u_acc (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .clear_i        (accept),
    .take_i         (ret),
    .idx_i          (idx),
    .data_i         (rom_data_i),
    .finish_i       (finish),
    .station_addr_o (station_addr_o),
    .done_o         (done_o),
    .valid_o        (valid_o),
    .fail_o         (fail_o)
  );

  // R8: the two result flags exclude each other
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(valid_o && fail_o));
  // R6: a failed completion leaves the address untouched
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && fail_o) |-> $stable(station_addr_o));
  // R10: an accepted start clears both result flags
  assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> (!valid_o && !fail_o));
  // R2: every read lands on a stride boundary
  assert_read_stride_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rom_rd_o |-> ((rom_addr_o % ADDR_W'(STRIDE)) == '0));
endmodule

// File: tb/hwaddr_rom_loader_test.sv
`timescale 1ns/1ps
module hwaddr_rom_loader_test;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        rom_rd_o;
  logic [7:0]  rom_addr_o;
  logic [7:0]  rom_data_i;
  logic [47:0] station_addr_o;
  logic        done_o, valid_o, fail_o;

  int checks = 0;
  int errs   = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  int rd_log [0:31];
  logic [7:0]  rom [0:255];
  logic [7:0]  dq  [0:LAT-1];
  logic [47:0] exp_addr;

  always #2.5 clk = ~clk;

  hwaddr_rom_loader #(.RD_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
    .station_addr_o(station_addr_o), .done_o(done_o),
    .valid_o(valid_o), .fail_o(fail_o)
  );

  always @(posedge clk) begin
    dq[0] <= rom_rd_o ? rom[rom_addr_o] : 8'h00;
    for (int i = 1; i < LAT; i++) dq[i] <= dq[i-1];
    if (rom_rd_o) begin
      if (rd_cnt < 32) rd_log[rd_cnt] <= int'(rom_addr_o);
      rd_cnt <= rd_cnt + 1;
    end
    if (done_o) done_cnt <= done_cnt + 1;
  end
  assign rom_data_i = dq[LAT-1];

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Store address a plus trailing byte t6; the last byte makes the check pass or not
  task automatic fill_rom(input logic [47:0] a, input logic [7:0] t6, input bit good);
    logic [7:0] x;
    logic [7:0] b;
    x = 8'h00;
    for (int j = 0; j < 6; j++) begin
      b = a[(5-j)*8 +: 8];
      x ^= b;
      rom[j*16] = flip(b);
    end
    rom[6*16] = flip(t6);
    b = 8'hFF ^ x ^ t6;
    if (!good) b ^= 8'h01;
    rom[7*16] = flip(b);
  endtask

  task automatic run_load(input bit extra_start);
    int w;
    rd_cnt   = 0;
    done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!valid_o && !fail_o, "R10", {valid_o, fail_o}, 2'b00);
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    w = 0;
    while (!done_o && w < 2000) begin
      @(negedge clk);
      w++;
    end
    chk(done_o, "R8", done_o, 1);
  endtask

  task automatic after_done(input bit expect_ok, input string req);
    chk(valid_o == expect_ok && fail_o == !expect_ok, req, {valid_o, fail_o}, {expect_ok, !expect_ok});
    chk(station_addr_o == exp_addr, req, station_addr_o, exp_addr);
    @(negedge clk);
    chk(!done_o, "R8", done_o, 0);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9", done_cnt, 1);
    chk(rd_cnt == 8, "R2", rd_cnt, 8);
    for (int j = 0; j < 8; j++)
      if (j < rd_cnt) chk(rd_log[j] == j*16, "R2", rd_log[j], j*16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 8'h5A ^ 8'(i);
    for (int i = 0; i < LAT; i++) dq[i] = 8'h00;
    rst_n = 1'b0;
    start = 1'b0;
    exp_addr = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!done_o && !valid_o && !fail_o, "R1", {done_o, valid_o, fail_o}, 0);
    chk(!rom_rd_o, "R1", rom_rd_o, 0);
    chk(station_addr_o == 48'h0, "R1", station_addr_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5: a mixed address
    fill_rom(48'h0012_34AB_CDEF, 8'h3C, 1'b1);
    exp_addr = 48'h0012_34AB_CDEF;
    run_load(1'b0);
    after_done(1'b1, "R5");

    // R3 R4 R11: a single set bit swept through every position
    for (int k = 0; k < 48; k++) begin
      fill_rom(48'h1 << k, 8'(k * 7), 1'b1);
      exp_addr = 48'h1 << k;
      run_load(1'b0);
      after_done(1'b1, "R4");
    end

    // R7: same address, different trailing bytes, still the same result
    fill_rom(48'hFEDC_BA98_7654, 8'h00, 1'b1);
    exp_addr = 48'hFEDC_BA98_7654;
    run_load(1'b0);
    after_done(1'b1, "R7");
    fill_rom(48'hFEDC_BA98_7654, 8'hE1, 1'b1);
    run_load(1'b0);
    after_done(1'b1, "R7");

    // R6: broken check keeps the previous address
    fill_rom(48'h0101_0202_0303, 8'h44, 1'b0);
    run_load(1'b0);
    after_done(1'b0, "R6");

    // R10: flags clear after the failure, then R9: a second start mid-load is ignored
    fill_rom(48'hA5A5_5A5A_C3C3, 8'h99, 1'b1);
    exp_addr = 48'hA5A5_5A5A_C3C3;
    run_load(1'b1);
    after_done(1'b1, "R9");

    // R5 then R6 with all-ones address bytes
    fill_rom(48'hFFFF_FFFF_FFFF, 8'hFF, 1'b1);
    exp_addr = 48'hFFFF_FFFF_FFFF;
    run_load(1'b0);
    after_done(1'b1, "R5");
    fill_rom(48'h0000_0000_0000, 8'h12, 1'b0);
    run_load(1'b0);
    after_done(1'b0, "R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule